// File: doc/BRIEF.md
# Three-Stage Clos Fabric Connection Controller

This block keeps the control state for a three-stage Clos switching fabric. The fabric has `R` ingress crossbars with `N` inputs each, `M` centre crossbars, and `R` egress crossbars with `N` outputs each. Every ingress crossbar has exactly one link to every centre crossbar, and every centre crossbar has exactly one link to every egress crossbar. A requester sends connect or disconnect commands that name a global input port and a global output port. For each new call the controller picks a centre crossbar and sets the select lines of all three stages. It carries no payload.

A connect is granted on the lowest-numbered centre crossbar whose link from the caller's ingress crossbar and whose link to the target egress crossbar are both idle. When `M >= 2N-1`, a connect between two idle ports is always granted. With fewer centre crossbars a connect can be blocked. A blocked request is reported and left alone, and existing calls are never moved. Each accepted command produces a single-cycle response that carries a status code and the centre index involved.

Top module: `clos_path_alloc`

## Requirements
- R1: Global port p (input or output) sits on crossbar p / N at local index p % N, and the select outputs follow this mapping.
- R2: A connect between an idle input and an idle output is granted on the lowest centre index k whose ingress link and egress link are both idle. It reports code 0 (grant) and k on `rsp_mid`. No crossbar ever holds more busy links to the centre stage than it has local ports.
- R3: `req_ready` is high whenever reset is not asserted. A command accepted at a clock edge gives `rsp_valid` high for exactly the following cycle, and `rsp_valid` is low in every other cycle.
- R4: After a grant for input p, output q and centre k, the following outputs are set. Ingress outlet k of crossbar p/N is enabled and selects local input p % N. Centre k's output toward egress crossbar q/N is enabled and selects ingress crossbar p/N. Global output q is enabled and selects centre k.
- R5: When M >= 2N-1, every connect between an idle input and an idle output is granted.
- R6: If no centre crossbar has both links idle, the response is code 1 (blocked). No link, port or select changes.
- R7: A connect naming a busy input, a busy output, or a port number >= N*R is answered with code 2 (error). No state changes.
- R8: A disconnect names the call by its input port; `req_out` is ignored. For an active call it answers code 0 with the call's centre index, frees both links and both ports, and clears the call's enables and selects to zero.
- R9: A disconnect naming an input with no call (or out of range) answers code 2 and changes nothing.
- R10: Reset clears all links, all port mappings, all enables and selects, and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command can be taken |
| req_disc | input | 1 | 1 = disconnect, 0 = connect |
| req_in | input | clog2(N*R) | Global input port |
| req_out | input | clog2(N*R) | Global output port (connect only) |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_code | output | 2 | 0 grant, 1 blocked, 2 error |
| rsp_mid | output | clog2(M) | Centre index of the granted or released call |
| ing_en | output | R*M | Ingress outlet enables, index i*M+k |
| ing_sel | output | R*M*clog2(N) | Local input selected per ingress outlet |
| mid_en | output | M*R | Centre output enables, index k*R+e |
| mid_sel | output | M*R*clog2(R) | Ingress crossbar selected per centre output |
| egr_en | output | N*R | Global output enables |
| egr_sel | output | N*R*clog2(M) | Centre crossbar selected per global output |

## Verification
The bench builds two copies of the block. The first uses N=2, M=3, R=3. It meets the strict non-blocking bound, so a long pseudo-random run of connects and disconnects must always grant calls between idle ports. Its six ports also leave port codes 6 and 7 unused, which makes the out-of-range error reachable. The second copy uses N=2, M=2, R=2, which is below that bound. A short directed sequence drives it into a blocked state with both ports idle, then frees a link and shows that the same request is granted.

// File: rtl/clos_pkg.sv
// Shared types for the Clos path allocator.
// Assumes: response codes are carried as 2-bit values on the top ports.
package clos_pkg;
    typedef enum logic [1:0] {
        RSP_GRANT   = 2'd0,
        RSP_BLOCKED = 2'd1,
        RSP_ERROR   = 2'd2
    } rsp_code_e;
endpackage

// File: rtl/clos_mid_pick.sv
// Finds the lowest set bit of a centre-crossbar availability vector.
// Assumes: free[k] is high when centre k has both needed links idle.
module clos_mid_pick #(
    parameter int M  = 3,
    parameter int MW = 2
) (
    input  logic [M-1:0]  free,
    output logic          found,
    output logic [MW-1:0] idx
);
    // Scan from the top down so the lowest free index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = M - 1; k >= 0; k--) begin
            if (free[k]) begin
                found = 1'b1;
                idx   = MW'(k);
            end
        end
    end
endmodule

// File: rtl/clos_sel_map.sv
// Flattens the stored link and select tables onto the crossbar control buses.
// Assumes: tables are indexed [crossbar][centre] for both ingress and egress
// sides; output buses use index i*M+k (ingress) and k*R+e (centre).
module clos_sel_map #(
    parameter int N  = 2,
    parameter int M  = 3,
    parameter int R  = 3,
    parameter int NW = 1,
    parameter int MW = 2,
    parameter int RW = 2,
    localparam int P = N * R
) (
    input  logic [M-1:0]      ing_link [R],
    input  logic [NW-1:0]     ing_src  [R][M],
    input  logic [M-1:0]      egr_link [R],
    input  logic [RW-1:0]     mid_src  [R][M],
    input  logic [P-1:0]      out_busy,
    input  logic [MW-1:0]     out_mid  [P],
    output logic [R*M-1:0]    ing_en,
    output logic [R*M*NW-1:0] ing_sel,
    output logic [M*R-1:0]    mid_en,
    output logic [M*R*RW-1:0] mid_sel,
    output logic [P-1:0]      egr_en,
    output logic [P*MW-1:0]   egr_sel
);
    for (genvar i = 0; i < R; i++) begin : g_sw
        for (genvar k = 0; k < M; k++) begin : g_ctr
            // Ingress outlet k of crossbar i.
            assign ing_en[i*M+k]             = ing_link[i][k];
            assign ing_sel[(i*M+k)*NW +: NW] = ing_src[i][k];
            // Centre k output toward egress crossbar i.
            assign mid_en[k*R+i]             = egr_link[i][k];
            assign mid_sel[(k*R+i)*RW +: RW] = mid_src[i][k];
        end
    end

    for (genvar o = 0; o < P; o++) begin : g_out
        // Egress select for global output o.
        assign egr_sel[o*MW +: MW] = out_mid[o];
    end
    assign egr_en = out_busy;
endmodule

// File: rtl/clos_path_alloc.sv
// Connection controller for an N/M/R three-stage Clos fabric.
// Takes one connect or disconnect command per cycle and answers one cycle
// later. Picks the lowest centre crossbar free on both of a call's links and
// never moves existing calls.
// Assumes: synchronous active-low reset; a disconnect is identified by its
// input port alone.
module clos_path_alloc
    import clos_pkg::*;
#(
    parameter int N = 2,
    parameter int M = 3,
    parameter int R = 3,
    localparam int P  = N * R,
    localparam int NW = (N > 1) ? $clog2(N) : 1,
    localparam int MW = (M > 1) ? $clog2(M) : 1,
    localparam int RW = (R > 1) ? $clog2(R) : 1,
    localparam int PW = (P > 1) ? $clog2(P) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_disc,
    input  logic [PW-1:0]     req_in,
    input  logic [PW-1:0]     req_out,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [MW-1:0]     rsp_mid,
    output logic [R*M-1:0]    ing_en,
    output logic [R*M*NW-1:0] ing_sel,
    output logic [M*R-1:0]    mid_en,
    output logic [M*R*RW-1:0] mid_sel,
    output logic [P-1:0]      egr_en,
    output logic [P*MW-1:0]   egr_sel
);
    localparam logic [PW:0] P_LIM = (PW + 1)'(P);
    localparam bit STRICT = (M >= 2 * N - 1);

    // Link and call state.
    logic [M-1:0]  ing_link [R];
    logic [NW-1:0] ing_src  [R][M];
    logic [M-1:0]  egr_link [R];
    logic [RW-1:0] mid_src  [R][M];
    logic [P-1:0]  in_busy, out_busy;
    logic [MW-1:0] in_mid   [P];
    logic [PW-1:0] in_out   [P];
    logic [MW-1:0] out_mid  [P];

    // Request decode.
    logic          accept, in_ok, out_ok, conn_idle;
    logic [RW-1:0] isw, esw, dsw;
    logic [NW-1:0] iloc;
    logic [PW-1:0] dout;
    logic [MW-1:0] dmid;
    logic [M-1:0]  free;
    logic          found;
    logic [MW-1:0] pick;
    rsp_code_e     nxt_code;
    logic [MW-1:0] nxt_mid;
    logic          do_conn, do_disc;

    assign accept    = req_valid && req_ready;
    assign in_ok     = {1'b0, req_in} < P_LIM;
    assign out_ok    = {1'b0, req_out} < P_LIM;
    assign isw       = RW'(32'(req_in) / N);
    assign iloc      = NW'(32'(req_in) % N);
    assign esw       = RW'(32'(req_out) / N);
    assign dout      = in_out[req_in];
    assign dmid      = in_mid[req_in];
    assign dsw       = RW'(32'(dout) / N);
    assign conn_idle = in_ok && out_ok && !in_busy[req_in] && !out_busy[req_out];
    assign free      = ~ing_link[isw] & ~egr_link[esw];

    clos_mid_pick #(.M(M), .MW(MW)) u_pick (
        .free  (free),
        .found (found),
        .idx   (pick)
    );

    // Decide the response code and which state update applies.
    always_comb begin
        nxt_code = RSP_ERROR;
        nxt_mid  = '0;
        do_conn  = 1'b0;
        do_disc  = 1'b0;
        if (req_disc) begin
            if (in_ok && in_busy[req_in]) begin
                nxt_code = RSP_GRANT;
                nxt_mid  = dmid;
                do_disc  = accept;
            end
        end else if (conn_idle) begin
            if (found) begin
                nxt_code = RSP_GRANT;
                nxt_mid  = pick;
                do_conn  = accept;
            end else begin
                nxt_code = RSP_BLOCKED;
            end
        end
    end

    // Register responses and apply connect/disconnect updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_ready <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            rsp_mid   <= '0;
            in_busy   <= '0;
            out_busy  <= '0;
            for (int i = 0; i < R; i++) begin
                ing_link[i] <= '0;
                egr_link[i] <= '0;
                for (int k = 0; k < M; k++) begin
                    ing_src[i][k] <= '0;
                    mid_src[i][k] <= '0;
                end
            end
            for (int p = 0; p < P; p++) begin
                in_mid[p]  <= '0;
                in_out[p]  <= '0;
                out_mid[p] <= '0;
            end
        end else begin
            req_ready <= 1'b1;
            rsp_valid <= accept;
            if (accept) begin
                rsp_code <= nxt_code;
                rsp_mid  <= nxt_mid;
            end
            if (do_conn) begin
                ing_link[isw][pick] <= 1'b1;
                ing_src[isw][pick]  <= iloc;
                egr_link[esw][pick] <= 1'b1;
                mid_src[esw][pick]  <= isw;
                in_busy[req_in]     <= 1'b1;
                in_mid[req_in]      <= pick;
                in_out[req_in]      <= req_out;
                out_busy[req_out]   <= 1'b1;
                out_mid[req_out]    <= pick;
            end
            if (do_disc) begin
                ing_link[isw][dmid] <= 1'b0;
                ing_src[isw][dmid]  <= '0;
                egr_link[dsw][dmid] <= 1'b0;
                mid_src[dsw][dmid]  <= '0;
                in_busy[req_in]     <= 1'b0;
                in_mid[req_in]      <= '0;
                in_out[req_in]      <= '0;
                out_busy[dout]      <= 1'b0;
                out_mid[dout]       <= '0;
            end
        end
    end

    clos_sel_map #(
        .N(N), .M(M), .R(R), .NW(NW), .MW(MW), .RW(RW)
    ) u_map (
        .ing_link (ing_link),
        .ing_src  (ing_src),
        .egr_link (egr_link),
        .mid_src  (mid_src),
        .out_busy (out_busy),
        .out_mid  (out_mid),
        .ing_en   (ing_en),
        .ing_sel  (ing_sel),
        .mid_en   (mid_en),
        .mid_sel  (mid_sel),
        .egr_en   (egr_en),
        .egr_sel  (egr_sel)
    );

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    // R3
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);
    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_ERROR) |-> ($stable(in_busy) && $stable(out_busy)));
    // R6
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_BLOCKED) |-> ($stable(in_busy) && $stable(out_busy)));
    // R8
    disc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_GRANT && $past(req_disc)) |-> !in_busy[$past(req_in)]);

    if (STRICT) begin : g_strict
        // R5
        strict_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && !req_disc && conn_idle) |=> (rsp_code == RSP_GRANT));
    end

    for (genvar i = 0; i < R; i++) begin : g_cap
        // R2
        link_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(ing_link[i]) <= N) && ($countones(egr_link[i]) <= N));
    end
endmodule

// File: tb/test_clos_path_alloc.sv
// Scoreboard bench: a driver task predicts each response from a port-level
// model and queues it; per-instance monitors pop and compare.
module test_clos_path_alloc;
    localparam int AN = 2, AM = 3, AR = 3, AP = 6, APW = 3, AMW = 2, ANW = 1, ARW = 2;
    localparam int BN = 2, BM = 2, BR = 2, BP = 4, BPW = 2, BMW = 1, BNW = 1, BRW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic a_valid, a_ready, a_disc, a_rv;
    logic [APW-1:0] a_in, a_out;
    logic [1:0] a_code;
    logic [AMW-1:0] a_mid;
    logic [AR*AM-1:0] a_ing_en;
    logic [AR*AM*ANW-1:0] a_ing_sel;
    logic [AM*AR-1:0] a_mid_en;
    logic [AM*AR*ARW-1:0] a_mid_sel;
    logic [AP-1:0] a_egr_en;
    logic [AP*AMW-1:0] a_egr_sel;

    logic b_valid, b_ready, b_disc, b_rv;
    logic [BPW-1:0] b_in, b_out;
    logic [1:0] b_code;
    logic [BMW-1:0] b_mid;
    logic [BR*BM-1:0] b_ing_en;
    logic [BR*BM*BNW-1:0] b_ing_sel;
    logic [BM*BR-1:0] b_mid_en;
    logic [BM*BR*BRW-1:0] b_mid_sel;
    logic [BP-1:0] b_egr_en;
    logic [BP*BMW-1:0] b_egr_sel;

    clos_path_alloc #(.N(AN), .M(AM), .R(AR)) i_clos_path_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready),
        .req_disc(a_disc), .req_in(a_in), .req_out(a_out), .rsp_valid(a_rv),
        .rsp_code(a_code), .rsp_mid(a_mid), .ing_en(a_ing_en), .ing_sel(a_ing_sel),
        .mid_en(a_mid_en), .mid_sel(a_mid_sel), .egr_en(a_egr_en), .egr_sel(a_egr_sel)
    );

    clos_path_alloc #(.N(BN), .M(BM), .R(BR)) i_clos_path_alloc_b (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
        .req_disc(b_disc), .req_in(b_in), .req_out(b_out), .rsp_valid(b_rv),
        .rsp_code(b_code), .rsp_mid(b_mid), .ing_en(b_ing_en), .ing_sel(b_ing_sel),
        .mid_en(b_mid_en), .mid_sel(b_mid_sel), .egr_en(b_egr_en), .egr_sel(b_egr_sel)
    );

    typedef struct {
        int    code;
        int    mid;
        string tag;
    } exp_t;

    exp_t qa[$];
    exp_t qb[$];
    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    // Port-level model, index 0 = instance A, 1 = instance B.
    int m_n[2];
    int m_m[2];
    int m_r[2];
    bit m_in_used[2][8];
    bit m_out_used[2][8];
    int m_in_mid[2][8];
    int m_in_out[2][8];
    bit m_ing[2][4][4];
    bit m_egr[2][4][4];

    task automatic check(bit ok, string tag, string what, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic model_clear();
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 8; p++) begin
                m_in_used[d][p] = 1'b0;
                m_out_used[d][p] = 1'b0;
                m_in_mid[d][p] = 0;
                m_in_out[d][p] = 0;
            end
            for (int i = 0; i < 4; i++)
                for (int k = 0; k < 4; k++) begin
                    m_ing[d][i][k] = 1'b0;
                    m_egr[d][i][k] = 1'b0;
                end
        end
    endtask

    // Predict, queue, and drive one command; response due one cycle later.
    task automatic send(int d, bit disc, int pin, int pout);
        exp_t e;
        int n = m_n[d];
        int p = m_n[d] * m_r[d];
        e.mid = -1;
        e.code = 2;
        if (disc) begin
            e.tag = "R9";
            if (pin < p && m_in_used[d][pin]) begin
                int o = m_in_out[d][pin];
                int k = m_in_mid[d][pin];
                e.code = 0;
                e.mid = k;
                e.tag = "R8";
                m_ing[d][pin/n][k] = 1'b0;
                m_egr[d][o/n][k] = 1'b0;
                m_in_used[d][pin] = 1'b0;
                m_out_used[d][o] = 1'b0;
            end
        end else if (pin >= p || pout >= p || m_in_used[d][pin] || m_out_used[d][pout]) begin
            e.tag = "R7";
        end else begin
            e.code = 1;
            e.tag = "R6";
            for (int k = m_m[d] - 1; k >= 0; k--)
                if (!m_ing[d][pin/n][k] && !m_egr[d][pout/n][k]) begin
                    e.code = 0;
                    e.mid = k;
                end
            if (e.code == 0) begin
                e.tag = (d == 0) ? "R5/R2" : "R2";
                m_ing[d][pin/n][e.mid] = 1'b1;
                m_egr[d][pout/n][e.mid] = 1'b1;
                m_in_used[d][pin] = 1'b1;
                m_out_used[d][pout] = 1'b1;
                m_in_mid[d][pin] = e.mid;
                m_in_out[d][pin] = pout;
            end
        end
        @(negedge clk);
        if (d == 0) begin
            qa.push_back(e);
            a_valid = 1'b1; a_disc = disc; a_in = APW'(pin); a_out = APW'(pout);
        end else begin
            qb.push_back(e);
            b_valid = 1'b1; b_disc = disc; b_in = BPW'(pin); b_out = BPW'(pout);
        end
        @(negedge clk);
        a_valid = 1'b0;
        b_valid = 1'b0;
        #1;
        // R3: the response must already have been consumed by the monitor.
        check((d == 0) ? (qa.size() == 0) : (qb.size() == 0), "R3", "response late", 0, 1);
    endtask

    // Compare every select and enable of instance A against the model.
    task automatic check_sel_a(string tag);
        logic [AR*AM-1:0] ie = '0;
        logic [AR*AM*ANW-1:0] is = '0;
        logic [AM*AR-1:0] me = '0;
        logic [AM*AR*ARW-1:0] ms = '0;
        logic [AP-1:0] ee = '0;
        logic [AP*AMW-1:0] es = '0;
        for (int p = 0; p < AP; p++) begin
            if (m_in_used[0][p]) begin
                int k = m_in_mid[0][p];
                int o = m_in_out[0][p];
                int sw = p / AN;
                int esw = o / AN;
                ie[sw*AM+k] = 1'b1;
                is[(sw*AM+k)*ANW +: ANW] = ANW'(p % AN);
                me[k*AR+esw] = 1'b1;
                ms[(k*AR+esw)*ARW +: ARW] = ARW'(sw);
                ee[o] = 1'b1;
                es[o*AMW +: AMW] = AMW'(k);
            end
        end
        check(a_ing_en == ie, {tag, "/R1/R4"}, "ing_en", int'(a_ing_en), int'(ie));
        check(a_ing_sel == is, {tag, "/R1/R4"}, "ing_sel", int'(a_ing_sel), int'(is));
        check(a_mid_en == me, {tag, "/R1/R4"}, "mid_en", int'(a_mid_en), int'(me));
        check(a_mid_sel == ms, {tag, "/R1/R4"}, "mid_sel", int'(a_mid_sel), int'(ms));
        check(a_egr_en == ee, {tag, "/R1/R4"}, "egr_en", int'(a_egr_en), int'(ee));
        check(a_egr_sel == es, {tag, "/R1/R4"}, "egr_sel", int'(a_egr_sel), int'(es));
    endtask

    // Monitor for instance A.
    always @(negedge clk) begin
        if (rst_n && a_rv) begin
            if (qa.size() == 0) begin
                check(1'b0, "R3", "A unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = qa.pop_front();
                check(int'(a_code) == e.code, e.tag, "A code", int'(a_code), e.code);
                if (e.mid >= 0)
                    check(int'(a_mid) == e.mid, e.tag, "A centre", int'(a_mid), e.mid);
                check_sel_a(e.tag);
            end
        end
    end

    // Monitor for instance B.
    always @(negedge clk) begin
        if (rst_n && b_rv) begin
            if (qb.size() == 0) begin
                check(1'b0, "R3", "B unexpected response", 1, 0);
            end else begin
                exp_t e;
                logic [BP-1:0] ee;
                e = qb.pop_front();
                check(int'(b_code) == e.code, e.tag, "B code", int'(b_code), e.code);
                if (e.mid >= 0)
                    check(int'(b_mid) == e.mid, e.tag, "B centre", int'(b_mid), e.mid);
                for (int p = 0; p < BP; p++) ee[p] = m_out_used[1][p];
                check(b_egr_en == ee, {e.tag, "/R6"}, "B egr_en", int'(b_egr_en), int'(ee));
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            nchk++;
            nfail++;
            $display("FAIL R3 watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        qa.delete();
        qb.delete();
        @(negedge clk);
        // R10: everything idle, ready raised one edge after release.
        check(a_ready && b_ready, "R10", "ready", int'(a_ready), 1);
        check(!a_rv && !b_rv, "R10", "rsp_valid", int'(a_rv), 0);
        check(a_ing_en == '0 && a_mid_en == '0 && a_egr_en == '0, "R10", "A enables",
              int'(a_egr_en), 0);
        check(a_ing_sel == '0 && a_mid_sel == '0 && a_egr_sel == '0, "R10", "A selects",
              int'(a_egr_sel), 0);
        check(b_ing_en == '0 && b_mid_en == '0 && b_egr_en == '0, "R10", "B enables",
              int'(b_egr_en), 0);
    endtask

    initial begin
        a_valid = 1'b0; a_disc = 1'b0; a_in = '0; a_out = '0;
        b_valid = 1'b0; b_disc = 1'b0; b_in = '0; b_out = '0;
        m_n[0] = AN; m_m[0] = AM; m_r[0] = AR;
        m_n[1] = BN; m_m[1] = BM; m_r[1] = BR;
        do_reset();

        // Instance A, directed: lowest centre, errors, disconnects.
        send(0, 1'b0, 0, 5);   // grant centre 0
        send(0, 1'b0, 1, 4);   // same ingress, centre 1
        send(0, 1'b0, 2, 3);   // ingress 1, egress 1: centre 0
        send(0, 1'b0, 0, 1);   // input busy -> error
        send(0, 1'b0, 3, 5);   // output busy -> error
        send(0, 1'b0, 6, 0);   // input out of range -> error
        send(0, 1'b0, 3, 7);   // output out of range -> error
        send(0, 1'b1, 4, 0);   // disconnect idle input -> error
        send(0, 1'b1, 7, 0);   // disconnect out of range -> error
        send(0, 1'b1, 0, 3);   // disconnect, req_out ignored
        send(0, 1'b0, 0, 0);   // reuse freed links

        // Instance A, pseudo-random traffic under the strict bound.
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 2);
            int pin = $urandom_range(0, 6);
            int pout = $urandom_range(0, 6);
            send(0, op == 0, pin, pout);
        end

        // Reset mid-run, then previously used ports must be free again.
        do_reset();
        send(0, 1'b0, 0, 5);
        send(0, 1'b0, 5, 0);

        // Instance B: reach a blocked state with both ports idle.
        send(1, 1'b0, 2, 2);   // centre 0
        send(1, 1'b0, 3, 3);   // centre 1
        send(1, 1'b1, 2, 0);   // free centre 0 toward egress 1
        send(1, 1'b0, 0, 0);   // centre 0
        send(1, 1'b0, 1, 2);   // blocked
        send(1, 1'b0, 1, 2);   // still blocked, nothing moved
        send(1, 1'b1, 3, 0);   // release centre 1
        send(1, 1'b0, 1, 2);   // now granted on centre 1
        send(1, 1'b0, 0, 3);   // input busy -> error

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule